// File: doc/BRIEF.md
# Vector Length State Unit

This unit holds the loop-length state of a parallel-loop extension that sits beside a scalar core: the maximum vector length, the current vector length, and the source and destination element offsets of the instruction in flight. It also holds a small configuration word that selects which rows of the register and predicate redirection tables are active, or switches the whole extension off. The issue loop reads the clamped fields and the active row range straight from its outputs.

Software reaches the unit through a CSR-style access port. Each access carries an address, write data, a flag that selects the immediate form, and the index of the destination register. The unit returns the value the core must write back, together with a writeback enable. The state word behaves like any ordinary CSR and hands back its previous contents. The vector-length register is different: it hands back the value it has just set, so a single access both sets the length and reports it. Every write is clamped so that the fields stay consistent with one another.

Top module: `vlen_state_unit`

## Requirements
- R1: A write to the state word (address ADDR_STATE) takes maxvl from bits 5:0, vl from bits 11:6, the source offset from bits 17:12 and the destination offset from bits 23:18. It clamps maxvl to at most XLEN-1 first, then vl to at most the new maxvl, then each offset to at most the new vl. The result appears on the field outputs one clock later.
- R2: A state word access returns the contents from before the write on rf_wdata, in the same layout, with bits 31:24 always zero. Write data in bits 31:24 has no effect.
- R3: A write to the vector-length register (address ADDR_VL) sets vl to exactly min(request, maxvl), compared over the full XLEN-bit request, and leaves maxvl unchanged. Any offset larger than the new vl is lowered to it.
- R4: A vector-length register access returns the newly set vl on rf_wdata, not the old one.
- R5: When rd_idx is 0, rf_we stays low but the CSR write still takes effect.
- R6: When csr_imm is 1, only csr_wdata[4:0] is used, zero-extended, so the immediate form can carry only the values 0 to 31.
- R7: The configuration word (address ADDR_CFG) holds size in bits 4:3 and bank in bits 2:0. Unless it is all ones, sv_on is 1 and the active rows run from row bank through row bank+(1<<size)-1, capped at row 7. These rows appear on row_mask, row_first and row_last.
- R8: A configuration word of all ones (5'h1F) disables the extension: sv_on=0, row_mask=0, row_first=row_last=0.
- R9: After reset, maxvl, vl and both offsets are 0 and the configuration word is 5'h1F, so the extension is disabled.
- R10: A configuration access returns the previous 5-bit word, zero-extended, on rf_wdata.
- R11: An access with csr_we low, or to any other address, changes no state and leaves rf_we low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Read-write access strobe |
| csr_imm | input | 1 | Immediate form: only data bits 4:0 are used |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data or immediate |
| rd_idx | input | 5 | Destination register index of the access |
| rf_we | output | 1 | Register writeback enable |
| rf_wdata | output | XLEN | Register writeback value |
| maxvl_o | output | 6 | Maximum vector length |
| vl_o | output | 6 | Current vector length |
| src_off_o | output | 6 | Source element offset |
| dst_off_o | output | 6 | Destination element offset |
| sv_on | output | 1 | Extension enabled |
| row_first | output | 3 | First active table row |
| row_last | output | 3 | Last active table row |
| row_mask | output | 8 | One bit per active table row |

## Verification
The bench builds the unit with XLEN=32 and eight table rows. With XLEN=32 the 6-bit maxvl field can be written with 63 and must fall to 31, so the first clamp stage is exercised along with the stages that follow it. Eight rows let the bench reach the configurations whose span runs past row 7 and has to be capped, along with the all-ones disable code. Vector-length requests above 63 check that the comparison uses the full register width.

// File: rtl/vls_pkg.sv
package vls_pkg;

    localparam int FIELD_W  = 6;
    localparam int STATE_W  = 4 * FIELD_W;
    localparam int SIZE_W   = 2;
    localparam int IMM_W    = 5;

    typedef logic [FIELD_W-1:0] field_t;

    // Packed so that the first member lands in the top bits of the word.
    typedef struct packed {
        field_t dst_off;
        field_t src_off;
        field_t vl;
        field_t maxvl;
    } vls_state_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_VL    = 2'd1,
        SEL_STATE = 2'd2,
        SEL_CFG   = 2'd3
    } csr_sel_e;

    function automatic field_t fmin(input field_t a, input field_t b);
        return (a < b) ? a : b;
    endfunction

    // Ordered clamp: maxvl against the cap, then vl, then both offsets.
    function automatic vls_state_t clamp_state(input vls_state_t raw, input field_t cap);
        vls_state_t r;
        r.maxvl   = fmin(raw.maxvl, cap);
        r.vl      = fmin(raw.vl, r.maxvl);
        r.src_off = fmin(raw.src_off, r.vl);
        r.dst_off = fmin(raw.dst_off, r.vl);
        return r;
    endfunction

endpackage

// File: rtl/vls_state_regs.sv
module vls_state_regs
    import vls_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_state,
    input  logic             wr_vl,
    input  vls_state_t       state_raw,
    input  logic [XLEN-1:0]  vl_req,
    output vls_state_t       state_q,
    output field_t           vl_new
);
    localparam field_t CAP = field_t'(XLEN - 1);

    vls_state_t clamped;
    vls_state_t vl_next;

    always_comb begin
        clamped = clamp_state(state_raw, CAP);
        if (vl_req > XLEN'(state_q.maxvl))
            vl_new = state_q.maxvl;
        else
            vl_new = vl_req[FIELD_W-1:0];
        vl_next         = state_q;
        vl_next.vl      = vl_new;
        vl_next.src_off = fmin(state_q.src_off, vl_new);
        vl_next.dst_off = fmin(state_q.dst_off, vl_new);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else if (wr_state)
            state_q <= clamped;
        else if (wr_vl)
            state_q <= vl_next;
    end

    // R1: maxvl never exceeds the register width minus one
    p_maxvl_cap_r1: assert property (@(posedge clk) disable iff (rst)
        state_q.maxvl <= CAP);

    // R1: vl never exceeds maxvl
    p_vl_bound_r1: assert property (@(posedge clk) disable iff (rst)
        state_q.vl <= state_q.maxvl);

    // R3: offsets never exceed vl
    p_off_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q.src_off <= state_q.vl) && (state_q.dst_off <= state_q.vl));

    // R11: without a write strobe the state holds
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(wr_state || wr_vl) |=> $stable(state_q));

    // R3: a length write leaves maxvl as it was
    p_vl_keeps_max_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_vl && !wr_state) |=> $stable(state_q.maxvl));

endmodule

// File: rtl/vls_cfg_rows.sv
module vls_cfg_rows
    import vls_pkg::*;
#(
    parameter int TBL_ROWS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_cfg,
    input  logic [SIZE_W+$clog2(TBL_ROWS)-1:0] cfg_in,
    output logic [SIZE_W+$clog2(TBL_ROWS)-1:0] cfg_q,
    output logic                        sv_on,
    output logic [$clog2(TBL_ROWS)-1:0] row_first,
    output logic [$clog2(TBL_ROWS)-1:0] row_last,
    output logic [TBL_ROWS-1:0]         row_mask
);
    localparam int BANK_W = $clog2(TBL_ROWS);
    localparam int CFG_W  = SIZE_W + BANK_W;
    localparam int LW     = BANK_W + (1 << SIZE_W) + 1;

    logic [BANK_W-1:0] bank;
    logic [SIZE_W-1:0] size;
    logic [LW-1:0]     span_end;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '1;
        else if (wr_cfg)
            cfg_q <= cfg_in;
    end

    always_comb begin
        bank     = cfg_q[BANK_W-1:0];
        size     = cfg_q[CFG_W-1:BANK_W];
        sv_on    = (cfg_q != '1);
        span_end = LW'(bank) + (LW'(1) << size) - LW'(1);
        if (!sv_on) begin
            row_first = '0;
            row_last  = '0;
        end else begin
            row_first = bank;
            if (span_end > LW'(TBL_ROWS - 1))
                row_last = BANK_W'(TBL_ROWS - 1);
            else
                row_last = span_end[BANK_W-1:0];
        end
    end

    for (genvar r = 0; r < TBL_ROWS; r++) begin : g_row
        assign row_mask[r] = sv_on && (BANK_W'(r) >= row_first) && (BANK_W'(r) <= row_last);
    end

    // R8: a disabled extension enables no row
    p_off_empty_r8: assert property (@(posedge clk) disable iff (rst)
        !sv_on |-> (row_mask == '0));

    // R7: the bank row is always part of an enabled range
    p_bank_row_r7: assert property (@(posedge clk) disable iff (rst)
        sv_on |-> row_mask[row_first]);

    // R7: the range never runs backwards
    p_range_order_r7: assert property (@(posedge clk) disable iff (rst)
        row_first <= row_last);

endmodule

// File: rtl/vlen_state_unit.sv
module vlen_state_unit
    import vls_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          TBL_ROWS   = 8,
    parameter logic [11:0] ADDR_VL    = 12'hC21,
    parameter logic [11:0] ADDR_STATE = 12'hC22,
    parameter logic [11:0] ADDR_CFG   = 12'hC23
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        csr_we,
    input  logic                        csr_imm,
    input  logic [11:0]                 csr_addr,
    input  logic [XLEN-1:0]             csr_wdata,
    input  logic [4:0]                  rd_idx,
    output logic                        rf_we,
    output logic [XLEN-1:0]             rf_wdata,
    output logic [FIELD_W-1:0]          maxvl_o,
    output logic [FIELD_W-1:0]          vl_o,
    output logic [FIELD_W-1:0]          src_off_o,
    output logic [FIELD_W-1:0]          dst_off_o,
    output logic                        sv_on,
    output logic [$clog2(TBL_ROWS)-1:0] row_first,
    output logic [$clog2(TBL_ROWS)-1:0] row_last,
    output logic [TBL_ROWS-1:0]         row_mask
);
    localparam int BANK_W = $clog2(TBL_ROWS);
    localparam int CFG_W  = SIZE_W + BANK_W;

    csr_sel_e          sel;
    logic [XLEN-1:0]   wdata_eff;
    vls_state_t        state_q;
    field_t            vl_new;
    logic [CFG_W-1:0]  cfg_q;

    always_comb begin
        sel = SEL_NONE;
        if (csr_we) begin
            if (csr_addr == ADDR_VL)         sel = SEL_VL;
            else if (csr_addr == ADDR_STATE) sel = SEL_STATE;
            else if (csr_addr == ADDR_CFG)   sel = SEL_CFG;
        end
        wdata_eff = csr_imm ? XLEN'(csr_wdata[IMM_W-1:0]) : csr_wdata;
    end

    vls_state_regs #(.XLEN(XLEN)) u_state (
        .clk       (clk),
        .rst       (rst),
        .wr_state  (sel == SEL_STATE),
        .wr_vl     (sel == SEL_VL),
        .state_raw (vls_state_t'(wdata_eff[STATE_W-1:0])),
        .vl_req    (wdata_eff),
        .state_q   (state_q),
        .vl_new    (vl_new)
    );

    vls_cfg_rows #(.TBL_ROWS(TBL_ROWS)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_cfg    (sel == SEL_CFG),
        .cfg_in    (wdata_eff[CFG_W-1:0]),
        .cfg_q     (cfg_q),
        .sv_on     (sv_on),
        .row_first (row_first),
        .row_last  (row_last),
        .row_mask  (row_mask)
    );

    always_comb begin
        rf_we = (sel != SEL_NONE) && (rd_idx != 5'd0);
        unique case (sel)
            SEL_VL:    rf_wdata = XLEN'(vl_new);
            SEL_STATE: rf_wdata = XLEN'(state_q);
            SEL_CFG:   rf_wdata = XLEN'(cfg_q);
            default:   rf_wdata = '0;
        endcase
    end

    assign maxvl_o   = state_q.maxvl;
    assign vl_o      = state_q.vl;
    assign src_off_o = state_q.src_off;
    assign dst_off_o = state_q.dst_off;

    // R4: the value handed back by a length write is the length that is then held
    p_vl_return_r4: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == ADDR_VL) |=> (vl_o == $past(rf_wdata[FIELD_W-1:0])));

    // R2: the state word read-back never carries bits above the fields
    p_state_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == ADDR_STATE) |-> (rf_wdata[XLEN-1:STATE_W] == '0));

endmodule

// File: tb/sim_vlen_state_unit.sv
module sim_vlen_state_unit;

    localparam int          XLEN   = 32;
    localparam logic [11:0] A_VL   = 12'hC21;
    localparam logic [11:0] A_ST   = 12'hC22;
    localparam logic [11:0] A_CFG  = 12'hC23;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic        csr_imm = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [4:0]  rd_idx = '0;
    logic        rf_we;
    logic [31:0] rf_wdata;
    logic [5:0]  maxvl_o, vl_o, src_off_o, dst_off_o;
    logic        sv_on;
    logic [2:0]  row_first, row_last;
    logic [7:0]  row_mask;

    always #10 clk = ~clk;

    vlen_state_unit #(.XLEN(XLEN), .TBL_ROWS(8), .ADDR_VL(A_VL),
                      .ADDR_STATE(A_ST), .ADDR_CFG(A_CFG)) u0 (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_imm(csr_imm),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .rd_idx(rd_idx),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .maxvl_o(maxvl_o), .vl_o(vl_o),
        .src_off_o(src_off_o), .dst_off_o(dst_off_o), .sv_on(sv_on),
        .row_first(row_first), .row_last(row_last), .row_mask(row_mask)
    );

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [5:0] m_max = 0, m_vl = 0, m_src = 0, m_dst = 0;
    logic [4:0] m_cfg = 5'h1F;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string sel_name(input int s);
        case (s)
            0: return "rf_we";      1: return "rf_wdata";
            2: return "maxvl_o";    3: return "vl_o";
            4: return "src_off_o";  5: return "dst_off_o";
            6: return "sv_on";      7: return "row_mask";
            8: return "row_first";  default: return "row_last";
        endcase
    endfunction

    function automatic logic [31:0] actual(input int s);
        case (s)
            0: return 32'(rf_we);     1: return rf_wdata;
            2: return 32'(maxvl_o);   3: return 32'(vl_o);
            4: return 32'(src_off_o); 5: return 32'(dst_off_o);
            6: return 32'(sv_on);     7: return 32'(row_mask);
            8: return 32'(row_first); default: return 32'(row_last);
        endcase
    endfunction

    function automatic logic [5:0] lo6(input logic [31:0] a, input logic [5:0] b);
        return (a < 32'(b)) ? a[5:0] : b;
    endfunction

    task automatic push(input int due, input int s, input logic [31:0] e, input string tag);
        item_t it;
        it.due = due; it.sel = s; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic push_state(input int due, input string tag);
        int first, last;
        logic [7:0] mask;
        mask = 0; first = 0; last = 0;
        if (m_cfg != 5'h1F) begin
            first = int'(m_cfg[2:0]);
            last  = first + (1 << m_cfg[4:3]) - 1;
            if (last > 7) last = 7;
            for (int r = first; r <= last; r++) mask[r] = 1'b1;
        end
        push(due, 2, 32'(m_max), tag);
        push(due, 3, 32'(m_vl), tag);
        push(due, 4, 32'(m_src), tag);
        push(due, 5, 32'(m_dst), tag);
        push(due, 6, 32'(m_cfg != 5'h1F), tag);
        push(due, 7, 32'(mask), tag);
        push(due, 8, 32'(first), tag);
        push(due, 9, 32'(last), tag);
    endtask

    // Driver: applies one access, predicts its results and pushes them.
    task automatic access(input logic we, input logic [11:0] addr, input logic [31:0] data,
                          input logic imm, input logic [4:0] rd, input string tag);
        logic [31:0] d, ret;
        logic        exp_we;
        @(negedge clk);
        #1;
        csr_we = we; csr_addr = addr; csr_wdata = data; csr_imm = imm; rd_idx = rd;
        d = imm ? {27'd0, data[4:0]} : data;
        exp_we = 1'b0;
        ret = 0;
        if (we && addr == A_ST) begin
            exp_we = (rd != 0);
            ret = {8'd0, m_dst, m_src, m_vl, m_max};
            m_max = lo6({26'd0, d[5:0]}, 6'd31);
            m_vl  = lo6({26'd0, d[11:6]}, m_max);
            m_src = lo6({26'd0, d[17:12]}, m_vl);
            m_dst = lo6({26'd0, d[23:18]}, m_vl);
        end else if (we && addr == A_VL) begin
            exp_we = (rd != 0);
            m_vl  = lo6(d, m_max);
            m_src = lo6(32'(m_src), m_vl);
            m_dst = lo6(32'(m_dst), m_vl);
            ret = 32'(m_vl);
        end else if (we && addr == A_CFG) begin
            exp_we = (rd != 0);
            ret = 32'(m_cfg);
            m_cfg = d[4:0];
        end
        push(cyc, 0, 32'(exp_we), tag);
        if (exp_we) push(cyc, 1, ret, tag);
        push_state(cyc + 1, tag);
        @(posedge clk);
        #1;
        csr_we = 1'b0;
    endtask

    // Monitor: compares every item when it falls due.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                logic [31:0] a;
                it = q.pop_front();
                a = actual(it.sel);
                checks++;
                if (it.due != cyc || a !== it.exp) begin
                    errors++;
                    $display("FAIL %s %s actual=%h expected=%h (due %0d at %0d)",
                             it.tag, sel_name(it.sel), a, it.exp, it.due, cyc);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R9: reset state
        access(1'b0, A_ST, 32'h0, 1'b0, 5'd1, "R9");

        // R1: full-scale write clamps maxvl to 31, then everything else to it
        access(1'b1, A_ST, 32'h00FF_FFFF, 1'b0, 5'd1, "R1");
        // R1, R2: ordered clamp; old value returned
        access(1'b1, A_ST, {8'd0, 6'd10, 6'd3, 6'd20, 6'd40}, 1'b0, 5'd2, "R1");
        access(1'b1, A_ST, {8'd0, 6'd2, 6'd7, 6'd9, 6'd5}, 1'b0, 5'd3, "R1");
        // R2: upper bits ignored and read back as zero
        access(1'b1, A_ST, {8'hAB, 6'd4, 6'd1, 6'd6, 6'd12}, 1'b0, 5'd4, "R2");
        access(1'b1, A_ST, {8'hFF, 6'd20, 6'd31, 6'd31, 6'd31}, 1'b0, 5'd4, "R2");

        // R3, R4: length write lowers offsets and returns the new length
        access(1'b1, A_VL, 32'd12, 1'b0, 5'd5, "R4");
        access(1'b1, A_VL, 32'd100, 1'b0, 5'd5, "R3");
        access(1'b1, A_VL, 32'h8000_0005, 1'b0, 5'd6, "R3");
        access(1'b1, A_VL, 32'd31, 1'b0, 5'd6, "R4");
        // R5: destination zero drops the writeback, write still lands
        access(1'b1, A_VL, 32'd7, 1'b0, 5'd0, "R5");
        access(1'b1, A_ST, {8'd0, 6'd1, 6'd1, 6'd3, 6'd9}, 1'b0, 5'd0, "R5");
        // R6: immediate form uses bits 4:0 only
        access(1'b1, A_VL, 32'hFFFF_FFE3, 1'b1, 5'd7, "R6");
        access(1'b1, A_ST, 32'h0000_07FF, 1'b1, 5'd7, "R6");
        access(1'b1, A_VL, 32'hFFFF_FFFF, 1'b1, 5'd7, "R6");

        // R7, R10: configuration ranges and old-value read-back
        access(1'b1, A_CFG, 32'h18, 1'b0, 5'd8, "R7");
        access(1'b1, A_CFG, 32'h19, 1'b0, 5'd8, "R7");
        access(1'b1, A_CFG, 32'h03, 1'b0, 5'd8, "R10");
        access(1'b1, A_CFG, 32'h0F, 1'b0, 5'd8, "R7");
        access(1'b1, A_CFG, 32'h15, 1'b0, 5'd8, "R7");
        access(1'b1, A_CFG, 32'h0A, 1'b0, 5'd8, "R7");
        // R8: all ones disables; immediate form reaches it in one access
        access(1'b1, A_CFG, 32'h3F, 1'b1, 5'd9, "R8");
        access(1'b1, A_CFG, 32'h00, 1'b1, 5'd9, "R10");
        access(1'b1, A_CFG, 32'h1F, 1'b0, 5'd9, "R8");

        // R11: unknown address and idle strobe change nothing
        access(1'b1, 12'h123, 32'hFFFF_FFFF, 1'b0, 5'd10, "R11");
        access(1'b0, A_VL, 32'd1, 1'b0, 5'd10, "R11");
        access(1'b0, A_CFG, 32'd0, 1'b0, 5'd10, "R11");
        access(1'b1, A_ST, 32'h0, 1'b0, 5'd11, "R2");

        repeat (3) @(negedge clk);
        #5;
        done = 1;
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL all pending actual=%0d expected=0", q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule